// File: doc/BRIEF.md
# Load/Store Split-Port Cache Bank Arbiter

This block sits between the load/store queue selector and the first-level data cache arrays. It makes a cache built from a two-port tag array and a set of single-port data banks act like a two-port cache. Each cycle the selector may offer one load and one store. Ports are dedicated by kind, so the two never compete for the same port.

Each store visits the cache twice. Its tag-check phase reads only the tag array and returns a hit flag and the matching way. Its data phase writes only one data bank, into the way learned earlier, under per-byte enables. A load reads both arrays at once. Tag lookups never interfere, because the tag array has one read port per kind.

A data-phase store that falls in the same data bank as the load of the same cycle is dropped. The load always wins. The dropped store's queue index is sent back on a one-cycle reject pulse so that the selector can issue it again. Refill is reduced to a line-install port that writes a tag and marks the line valid. Replacement and coherence are outside the block.

Top module: `lsdp_bank_arbiter`

## Requirements
- R1: After reset every line is invalid and all response, check and reject valid outputs are low; a load to any address then reports a miss.
- R2: A load presented in cycle n returns, in cycle n+3 only, its queue index, a hit flag, and the 64-bit word at the address from the matching way; on a miss the data is zero.
- R3: A tag-check store (st_phase = 0) returns, in cycle n+3 only, its index, hit flag and matching way. It writes no data and is never rejected, even when it shares a bank with the load.
- R4: A data store (st_phase = 1) writes byte i of st_data (bits 8i+7..8i) into way st_way of the addressed word when st_be[i] is 1. Bytes with a clear enable keep their old value.
- R5: The data bank is address bits [5:3]. When a load and a data store in the same cycle select the same bank, the store is discarded and leaves memory unchanged, while the load completes normally.
- R6: When a load and a data store in the same cycle select different banks, both complete in that cycle.
- R7: A discarded store raises st_rej_valid for exactly the following cycle, with st_rej_idx equal to its index; no other cycle has st_rej_valid high.
- R8: A line install (fill_valid) writes the tag of fill_addr into way fill_way of its set and marks the line valid. Lookups in later cycles hit it.
- R9: A load and a tag-check store in the same cycle both receive correct tag results.
- R10: A data store issued without a load in the same cycle is never rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_valid | input | 1 | Install a line tag |
| fill_addr | input | 32 | Address of the installed line |
| fill_way | input | 2 | Way receiving the line |
| ld_valid | input | 1 | Load request |
| ld_addr | input | 32 | Load byte address |
| ld_idx | input | 4 | Load queue index |
| st_valid | input | 1 | Store request |
| st_phase | input | 1 | 0 tag check, 1 data write |
| st_addr | input | 32 | Store byte address |
| st_idx | input | 4 | Store queue index |
| st_way | input | 2 | Way for a data write |
| st_data | input | 64 | Store data word |
| st_be | input | 8 | Per-byte write enables |
| ld_rsp_valid | output | 1 | Load response valid |
| ld_rsp_idx | output | 4 | Load response index |
| ld_rsp_hit | output | 1 | Load hit |
| ld_rsp_data | output | 64 | Load data |
| st_chk_valid | output | 1 | Tag-check result valid |
| st_chk_idx | output | 4 | Tag-check index |
| st_chk_hit | output | 1 | Tag-check hit |
| st_chk_way | output | 2 | Matching way |
| st_rej_valid | output | 1 | Store discarded |
| st_rej_idx | output | 4 | Index of the discarded store |

## Verification
The hardest case to reach from the ports is a load and a data-phase store in the same bank in the same cycle, with both lines already installed and holding known data. That state is needed to show that the dropped store really left memory alone. The stimulus builds it directly, then runs a long random phase in which addresses come from three tags, four sets and four word offsets. In that phase all eight banks, bank clashes and back-to-back rejects occur often. A behavioural model of tags and bytes predicts every output slot cycle by cycle.

// File: rtl/lsdp_pkg.sv
package lsdp_pkg;
    // store phase encoding on st_phase
    typedef enum logic {
        PH_TAG  = 1'b0,
        PH_DATA = 1'b1
    } st_phase_e;

    // lookup port numbering inside the tag array
    localparam int TP_LOAD  = 0;
    localparam int TP_STORE = 1;
endpackage

// File: rtl/lsdp_tag_array.sv
module lsdp_tag_array #(
    parameter int SETS  = 512,
    parameter int WAYS  = 4,
    parameter int TAG_W = 18,
    parameter int SET_W = 9,
    parameter int WAY_W = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      fill_en,
    input  logic [SET_W-1:0]          fill_set,
    input  logic [WAY_W-1:0]          fill_way,
    input  logic [TAG_W-1:0]          fill_tag,
    input  logic [1:0]                rd_en,
    input  logic [1:0][SET_W-1:0]     rd_set,
    input  logic [1:0][TAG_W-1:0]     cmp_tag,
    output logic [1:0]                rd_hit,
    output logic [1:0][WAY_W-1:0]     rd_way
);
    logic [TAG_W-1:0] tag_mem [SETS][WAYS];
    logic [WAYS-1:0]  vld_q   [SETS];

    always_ff @(posedge clk) begin
        if (fill_en) tag_mem[fill_set][fill_way] <= fill_tag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
        end else if (fill_en) begin
            vld_q[fill_set][fill_way] <= 1'b1;
        end
    end

    for (genvar p = 0; p < 2; p++) begin : g_port
        logic [WAYS-1:0][TAG_W-1:0] rtag_q;
        logic [WAYS-1:0]            rvld_q;
        logic [WAYS-1:0]            match;
        logic                       hit_l;
        logic [WAY_W-1:0]           way_l;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          rvld_q <= '0;
            else if (rd_en[p])   rvld_q <= vld_q[rd_set[p]];
        end

        always_ff @(posedge clk) begin
            if (rd_en[p]) begin
                for (int w = 0; w < WAYS; w++) rtag_q[w] <= tag_mem[rd_set[p]][w];
            end
        end

        always_comb begin
            hit_l = 1'b0;
            way_l = '0;
            for (int w = 0; w < WAYS; w++) begin
                match[w] = rvld_q[w] && (rtag_q[w] == cmp_tag[p]);
                if (match[w]) begin
                    hit_l = 1'b1;
                    way_l = WAY_W'(w);
                end
            end
        end

        assign rd_hit[p] = hit_l;
        assign rd_way[p] = way_l;

        // R8
        tag_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(match));
    end
endmodule

// File: rtl/lsdp_data_bank.sv
module lsdp_data_bank #(
    parameter int ROWS   = 256,
    parameter int ROW_W  = 8,
    parameter int WAYS   = 4,
    parameter int WAY_W  = 2,
    parameter int WORD_B = 8
) (
    input  logic                        clk,
    input  logic                        rd_en,
    input  logic [ROW_W-1:0]            rd_row,
    output logic [WAYS*WORD_B*8-1:0]    rd_data,
    input  logic                        wr_en,
    input  logic [ROW_W-1:0]            wr_row,
    input  logic [WAY_W-1:0]            wr_way,
    input  logic [WORD_B-1:0]           wr_be,
    input  logic [WORD_B*8-1:0]         wr_data
);
    localparam int ROW_BITS = WAYS * WORD_B * 8;

    logic [ROW_BITS-1:0] mem [ROWS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int i = 0; i < WORD_B; i++) begin
                if (wr_be[i]) mem[wr_row][(int'(wr_way) * WORD_B + i) * 8 +: 8] <= wr_data[i*8 +: 8];
            end
        end
        if (rd_en) rd_data <= mem[rd_row];
    end
endmodule

// File: rtl/lsdp_port_route.sv
module lsdp_port_route #(
    parameter int BANKS  = 8,
    parameter int BANK_W = 3
) (
    input  logic              ld_valid,
    input  logic [BANK_W-1:0] ld_bank,
    input  logic              st_valid,
    input  logic              st_phase,
    input  logic [BANK_W-1:0] st_bank,
    output logic [BANKS-1:0]  bank_rd,
    output logic [BANKS-1:0]  bank_we,
    output logic              tag_st_en,
    output logic              st_drop
);
    import lsdp_pkg::*;

    logic st_data_ph;
    logic clash;

    assign st_data_ph = st_valid && (st_phase == PH_DATA);
    assign tag_st_en  = st_valid && (st_phase == PH_TAG);
    assign clash      = ld_valid && st_data_ph && (ld_bank == st_bank);
    assign st_drop    = clash;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        assign bank_rd[b] = ld_valid && (ld_bank == BANK_W'(b));
        assign bank_we[b] = st_data_ph && !clash && (st_bank == BANK_W'(b));
    end
endmodule

// File: rtl/lsdp_bank_arbiter.sv
module lsdp_bank_arbiter #(
    parameter int ADDR_W      = 32,
    parameter int CACHE_BYTES = 65536,
    parameter int WAYS        = 4,
    parameter int LINE_BYTES  = 32,
    parameter int BANKS       = 8,
    parameter int WORD_BYTES  = 8,
    parameter int IDX_W       = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fill_valid,
    input  logic [ADDR_W-1:0]       fill_addr,
    input  logic [$clog2(WAYS)-1:0] fill_way,
    input  logic                    ld_valid,
    input  logic [ADDR_W-1:0]       ld_addr,
    input  logic [IDX_W-1:0]        ld_idx,
    input  logic                    st_valid,
    input  logic                    st_phase,
    input  logic [ADDR_W-1:0]       st_addr,
    input  logic [IDX_W-1:0]        st_idx,
    input  logic [$clog2(WAYS)-1:0] st_way,
    input  logic [WORD_BYTES*8-1:0] st_data,
    input  logic [WORD_BYTES-1:0]   st_be,
    output logic                    ld_rsp_valid,
    output logic [IDX_W-1:0]        ld_rsp_idx,
    output logic                    ld_rsp_hit,
    output logic [WORD_BYTES*8-1:0] ld_rsp_data,
    output logic                    st_chk_valid,
    output logic [IDX_W-1:0]        st_chk_idx,
    output logic                    st_chk_hit,
    output logic [$clog2(WAYS)-1:0] st_chk_way,
    output logic                    st_rej_valid,
    output logic [IDX_W-1:0]        st_rej_idx
);
    import lsdp_pkg::*;

    localparam int SETS     = CACHE_BYTES / (WAYS * LINE_BYTES);
    localparam int OFF_W    = $clog2(LINE_BYTES);
    localparam int SET_W    = $clog2(SETS);
    localparam int TAG_W    = ADDR_W - OFF_W - SET_W;
    localparam int WAY_W    = $clog2(WAYS);
    localparam int BANK_W   = $clog2(BANKS);
    localparam int BYTE_W   = $clog2(WORD_BYTES);
    localparam int WORD_W   = WORD_BYTES * 8;
    localparam int ROWS     = SETS * LINE_BYTES / (BANKS * WORD_BYTES);
    localparam int ROW_W    = $clog2(ROWS);
    localparam int ROW_BITS = WAYS * WORD_W;
    localparam int BANK_LSB = BYTE_W;
    localparam int ROW_LSB  = BYTE_W + BANK_W;

    typedef struct packed {
        logic              ld_v;
        logic [IDX_W-1:0]  ld_idx;
        logic [TAG_W-1:0]  ld_tag;
        logic [BANK_W-1:0] ld_bank;
        logic              ck_v;
        logic [IDX_W-1:0]  ck_idx;
        logic [TAG_W-1:0]  ck_tag;
    } lookup_t;

    typedef struct packed {
        logic              ld_v;
        logic [IDX_W-1:0]  ld_idx;
        logic              ld_hit;
        logic [WORD_W-1:0] ld_data;
        logic              ck_v;
        logic [IDX_W-1:0]  ck_idx;
        logic              ck_hit;
        logic [WAY_W-1:0]  ck_way;
    } result_t;

    typedef struct packed {
        lookup_t          s1;
        result_t          s2;
        result_t          s3;
        logic             rej_v;
        logic [IDX_W-1:0] rej_idx;
    } pipe_t;

    pipe_t st_d, st_q;

    // address fields
    logic [BANK_W-1:0] ld_bank, st_bank;
    logic [ROW_W-1:0]  ld_row, st_row;
    logic [SET_W-1:0]  ld_set, st_set, fill_set;
    logic [TAG_W-1:0]  ld_tag, st_tag, fill_tag;

    assign ld_bank  = ld_addr[BANK_LSB +: BANK_W];
    assign st_bank  = st_addr[BANK_LSB +: BANK_W];
    assign ld_row   = ld_addr[ROW_LSB +: ROW_W];
    assign st_row   = st_addr[ROW_LSB +: ROW_W];
    assign ld_set   = ld_addr[OFF_W +: SET_W];
    assign st_set   = st_addr[OFF_W +: SET_W];
    assign fill_set = fill_addr[OFF_W +: SET_W];
    assign ld_tag   = ld_addr[ADDR_W-1 -: TAG_W];
    assign st_tag   = st_addr[ADDR_W-1 -: TAG_W];
    assign fill_tag = fill_addr[ADDR_W-1 -: TAG_W];

    logic unused_addr_bits;
    assign unused_addr_bits = ^{ld_addr[BYTE_W-1:0], st_addr[BYTE_W-1:0], fill_addr[OFF_W-1:0]};

    // routing and bank-clash decision
    logic [BANKS-1:0] bank_rd, bank_we;
    logic             tag_st_en, st_drop;

    lsdp_port_route #(.BANKS(BANKS), .BANK_W(BANK_W)) u_route (
        .ld_valid  (ld_valid),
        .ld_bank   (ld_bank),
        .st_valid  (st_valid),
        .st_phase  (st_phase),
        .st_bank   (st_bank),
        .bank_rd   (bank_rd),
        .bank_we   (bank_we),
        .tag_st_en (tag_st_en),
        .st_drop   (st_drop)
    );

    // two-port tag array: port TP_LOAD for loads, TP_STORE for tag-check stores
    logic [1:0]             tag_rd_en;
    logic [1:0][SET_W-1:0]  tag_rd_set;
    logic [1:0][TAG_W-1:0]  tag_cmp;
    logic [1:0]             tag_hit;
    logic [1:0][WAY_W-1:0]  tag_way;

    assign tag_rd_en[TP_LOAD]   = ld_valid;
    assign tag_rd_en[TP_STORE]  = tag_st_en;
    assign tag_rd_set[TP_LOAD]  = ld_set;
    assign tag_rd_set[TP_STORE] = st_set;
    assign tag_cmp[TP_LOAD]     = st_q.s1.ld_tag;
    assign tag_cmp[TP_STORE]    = st_q.s1.ck_tag;

    lsdp_tag_array #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .SET_W(SET_W), .WAY_W(WAY_W)
    ) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .fill_en  (fill_valid),
        .fill_set (fill_set),
        .fill_way (fill_way),
        .fill_tag (fill_tag),
        .rd_en    (tag_rd_en),
        .rd_set   (tag_rd_set),
        .cmp_tag  (tag_cmp),
        .rd_hit   (tag_hit),
        .rd_way   (tag_way)
    );

    // single-port data banks, each row holding every way of one word slot
    logic [ROW_BITS-1:0] bank_rd_data [BANKS];

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        lsdp_data_bank #(
            .ROWS(ROWS), .ROW_W(ROW_W), .WAYS(WAYS), .WAY_W(WAY_W), .WORD_B(WORD_BYTES)
        ) u_bank (
            .clk     (clk),
            .rd_en   (bank_rd[b]),
            .rd_row  (ld_row),
            .rd_data (bank_rd_data[b]),
            .wr_en   (bank_we[b]),
            .wr_row  (st_row),
            .wr_way  (st_way),
            .wr_be   (st_be),
            .wr_data (st_data)
        );
    end

    logic [ROW_BITS-1:0] sel_row;
    logic [WORD_W-1:0]   sel_word;

    always_comb begin
        sel_row  = bank_rd_data[st_q.s1.ld_bank];
        sel_word = sel_row[int'(tag_way[TP_LOAD]) * WORD_W +: WORD_W];
    end

    always_comb begin
        st_d = st_q;

        st_d.s1.ld_v    = ld_valid;
        st_d.s1.ld_idx  = ld_idx;
        st_d.s1.ld_tag  = ld_tag;
        st_d.s1.ld_bank = ld_bank;
        st_d.s1.ck_v    = tag_st_en;
        st_d.s1.ck_idx  = st_idx;
        st_d.s1.ck_tag  = st_tag;

        st_d.s2.ld_v    = st_q.s1.ld_v;
        st_d.s2.ld_idx  = st_q.s1.ld_idx;
        st_d.s2.ld_hit  = st_q.s1.ld_v && tag_hit[TP_LOAD];
        st_d.s2.ld_data = st_d.s2.ld_hit ? sel_word : '0;
        st_d.s2.ck_v    = st_q.s1.ck_v;
        st_d.s2.ck_idx  = st_q.s1.ck_idx;
        st_d.s2.ck_hit  = st_q.s1.ck_v && tag_hit[TP_STORE];
        st_d.s2.ck_way  = tag_way[TP_STORE];

        st_d.s3         = st_q.s2;

        st_d.rej_v      = st_drop;
        st_d.rej_idx    = st_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ld_rsp_valid = st_q.s3.ld_v;
    assign ld_rsp_idx   = st_q.s3.ld_idx;
    assign ld_rsp_hit   = st_q.s3.ld_hit;
    assign ld_rsp_data  = st_q.s3.ld_data;
    assign st_chk_valid = st_q.s3.ck_v;
    assign st_chk_idx   = st_q.s3.ck_idx;
    assign st_chk_hit   = st_q.s3.ck_hit;
    assign st_chk_way   = st_q.s3.ck_way;
    assign st_rej_valid = st_q.rej_v;
    assign st_rej_idx   = st_q.rej_idx;

    // R7
    rej_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_rej_valid |-> $past(ld_valid && st_valid && st_phase &&
                               (ld_addr[BANK_LSB +: BANK_W] == st_addr[BANK_LSB +: BANK_W])));

    // R5
    we_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_we));

    // R5
    ld_bank_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> !bank_we[ld_addr[BANK_LSB +: BANK_W]]);

    // R2
    ld_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_rsp_valid |-> $past(ld_valid, 3));

    // R3
    chk_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_chk_valid |-> $past(st_valid && !st_phase, 3));

    // R3
    tag_store_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_phase) |-> (bank_we == '0));
endmodule

// File: tb/lsdp_bank_arbiter_bench.sv
module lsdp_bank_arbiter_bench;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic        fill_valid;
    logic [31:0] fill_addr;
    logic [1:0]  fill_way;
    logic        ld_valid;
    logic [31:0] ld_addr;
    logic [3:0]  ld_idx;
    logic        st_valid, st_phase;
    logic [31:0] st_addr;
    logic [3:0]  st_idx;
    logic [1:0]  st_way;
    logic [63:0] st_data;
    logic [7:0]  st_be;
    logic        ld_rsp_valid, ld_rsp_hit, st_chk_valid, st_chk_hit, st_rej_valid;
    logic [3:0]  ld_rsp_idx, st_chk_idx, st_rej_idx;
    logic [63:0] ld_rsp_data;
    logic [1:0]  st_chk_way;

    lsdp_bank_arbiter u_lsdp_bank_arbiter (
        .clk(clk), .rst_n(rst_n),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_way(fill_way),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_idx(ld_idx),
        .st_valid(st_valid), .st_phase(st_phase), .st_addr(st_addr), .st_idx(st_idx),
        .st_way(st_way), .st_data(st_data), .st_be(st_be),
        .ld_rsp_valid(ld_rsp_valid), .ld_rsp_idx(ld_rsp_idx), .ld_rsp_hit(ld_rsp_hit),
        .ld_rsp_data(ld_rsp_data),
        .st_chk_valid(st_chk_valid), .st_chk_idx(st_chk_idx), .st_chk_hit(st_chk_hit),
        .st_chk_way(st_chk_way),
        .st_rej_valid(st_rej_valid), .st_rej_idx(st_rej_idx)
    );

    int checks = 0;
    int errors = 0;
    int n = 0;

    // reference state
    bit [17:0]   mtag [int];
    bit          mvld [int];
    byte unsigned mdat [int];

    // expected output slots, indexed by cycle modulo 8
    bit          e_ld_v [8];
    bit [3:0]    e_ld_idx [8];
    bit          e_ld_hit [8];
    bit          e_ld_dchk [8];
    logic [63:0] e_ld_data [8];
    bit          e_ck_v [8];
    bit [3:0]    e_ck_idx [8];
    bit          e_ck_hit [8];
    bit [1:0]    e_ck_way [8];
    bit          e_rj_v [8];
    bit [3:0]    e_rj_idx [8];
    string       lbl [8];
    string       rlbl [8];

    function automatic logic [31:0] mk(input int tg, input int set, input int wd);
        return {18'(tg), 9'(set), 2'(wd), 3'b000};
    endfunction

    function automatic int lookup(input logic [31:0] a);
        int s = int'(a[13:5]);
        for (int w = 0; w < 4; w++) begin
            if (mvld.exists(s*4+w) && mvld[s*4+w] && mtag[s*4+w] == a[31:14]) return w;
        end
        return -1;
    endfunction

    function automatic int dkey(input logic [31:0] a, input int w, input int b);
        return (((int'(a[13:5]) * 4 + w) * 4 + int'(a[4:3])) * 8) + b;
    endfunction

    task automatic idle();
        fill_valid = 0; fill_addr = '0; fill_way = '0;
        ld_valid = 0; ld_addr = '0; ld_idx = '0;
        st_valid = 0; st_phase = 0; st_addr = '0; st_idx = '0;
        st_way = '0; st_data = '0; st_be = '0;
    endtask

    task automatic verify(input int k);
        checks++;
        if (ld_rsp_valid !== e_ld_v[k] ||
            (e_ld_v[k] && (ld_rsp_idx !== e_ld_idx[k] || ld_rsp_hit !== e_ld_hit[k] ||
                           (e_ld_dchk[k] && ld_rsp_data !== e_ld_data[k])))) begin
            errors++;
            $display("FAIL %s load rsp: v=%0b idx=%0d hit=%0b data=%h expected v=%0b idx=%0d hit=%0b data=%h",
                     lbl[k], ld_rsp_valid, ld_rsp_idx, ld_rsp_hit, ld_rsp_data,
                     e_ld_v[k], e_ld_idx[k], e_ld_hit[k], e_ld_data[k]);
        end
        checks++;
        if (st_chk_valid !== e_ck_v[k] ||
            (e_ck_v[k] && (st_chk_idx !== e_ck_idx[k] || st_chk_hit !== e_ck_hit[k] ||
                           (e_ck_hit[k] && st_chk_way !== e_ck_way[k])))) begin
            errors++;
            $display("FAIL %s tag check: v=%0b idx=%0d hit=%0b way=%0d expected v=%0b idx=%0d hit=%0b way=%0d",
                     lbl[k], st_chk_valid, st_chk_idx, st_chk_hit, st_chk_way,
                     e_ck_v[k], e_ck_idx[k], e_ck_hit[k], e_ck_way[k]);
        end
        checks++;
        if (st_rej_valid !== e_rj_v[k] || (e_rj_v[k] && st_rej_idx !== e_rj_idx[k])) begin
            errors++;
            $display("FAIL %s reject: v=%0b idx=%0d expected v=%0b idx=%0d",
                     rlbl[k], st_rej_valid, st_rej_idx, e_rj_v[k], e_rj_idx[k]);
        end
        e_ld_v[k] = 0; e_ck_v[k] = 0; e_rj_v[k] = 0; e_ld_dchk[k] = 0;
        lbl[k] = "R2 R3"; rlbl[k] = "R7";
    endtask

    // predict results of the inputs now applied, advance one cycle, compare
    task automatic tick(input string rq);
        int s3 = (n + 3) % 8;
        int s1 = (n + 1) % 8;
        lbl[s3] = rq;
        rlbl[s1] = rq;
        if (ld_valid) begin
            int lw = lookup(ld_addr);
            bit ok = 1;
            e_ld_v[s3] = 1; e_ld_idx[s3] = ld_idx; e_ld_hit[s3] = (lw >= 0);
            e_ld_data[s3] = '0;
            if (lw >= 0) begin
                for (int b = 0; b < 8; b++) begin
                    int k = dkey(ld_addr, lw, b);
                    if (mdat.exists(k)) e_ld_data[s3][b*8 +: 8] = mdat[k];
                    else ok = 0;
                end
            end
            e_ld_dchk[s3] = ok;
        end
        if (st_valid && !st_phase) begin
            int cw = lookup(st_addr);
            e_ck_v[s3] = 1; e_ck_idx[s3] = st_idx; e_ck_hit[s3] = (cw >= 0);
            e_ck_way[s3] = (cw >= 0) ? 2'(cw) : 2'd0;
        end
        if (st_valid && st_phase) begin
            if (ld_valid && ld_addr[5:3] == st_addr[5:3]) begin
                e_rj_v[s1] = 1; e_rj_idx[s1] = st_idx;
            end else begin
                for (int b = 0; b < 8; b++)
                    if (st_be[b]) mdat[dkey(st_addr, int'(st_way), b)] = st_data[b*8 +: 8];
            end
        end
        if (fill_valid) begin
            int fk = int'(fill_addr[13:5]) * 4 + int'(fill_way);
            mvld[fk] = 1; mtag[fk] = fill_addr[31:14];
        end
        @(negedge clk);
        n++;
        verify(n % 8);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] a, a2, a3;
        idle();
        rst_n = 0;
        for (int k = 0; k < 8; k++) begin lbl[k] = "R2 R3"; rlbl[k] = "R7"; end
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        checks++;
        if (ld_rsp_valid !== 0 || st_chk_valid !== 0 || st_rej_valid !== 0) begin
            errors++;
            $display("FAIL R1 reset outputs: ld=%0b chk=%0b rej=%0b expected 0 0 0",
                     ld_rsp_valid, st_chk_valid, st_rej_valid);
        end

        a  = mk(5, 2, 1);   // bank 1
        a2 = mk(9, 4, 1);   // bank 1, other set
        a3 = mk(5, 2, 2);   // bank 2, same line as a

        // R1 miss after reset
        ld_valid = 1; ld_addr = a; ld_idx = 4'd3; tick("R1");
        idle(); repeat (3) tick("R1");

        // R8 install lines
        fill_valid = 1; fill_addr = a; fill_way = 2'd2; tick("R8");
        idle(); fill_valid = 1; fill_addr = a2; fill_way = 2'd0; tick("R8");
        idle(); ld_valid = 1; ld_addr = a2; ld_idx = 4'd1; tick("R8");

        // R10 data stores with no load
        idle(); st_valid = 1; st_phase = 1; st_addr = a; st_idx = 4'd7; st_way = 2'd2;
        st_data = 64'h1111_2222_3333_4444; st_be = 8'hFF; tick("R10");
        idle(); st_valid = 1; st_phase = 1; st_addr = a2; st_idx = 4'd8; st_way = 2'd0;
        st_data = 64'h0102_0304_0506_0708; st_be = 8'hFF; tick("R10");
        idle(); st_valid = 1; st_phase = 1; st_addr = a3; st_idx = 4'd9; st_way = 2'd2;
        st_data = 64'hCAFE_0000_BEEF_0000; st_be = 8'hFF; tick("R10");

        // R9 load and tag check together
        idle(); ld_valid = 1; ld_addr = a; ld_idx = 4'd2;
        st_valid = 1; st_phase = 0; st_addr = a; st_idx = 4'd5; tick("R9");

        // R4 partial byte write then read back
        idle(); st_valid = 1; st_phase = 1; st_addr = a; st_idx = 4'd6; st_way = 2'd2;
        st_data = 64'hAAAA_AAAA_AAAA_AAAA; st_be = 8'h0F; tick("R4");
        idle(); ld_valid = 1; ld_addr = a; ld_idx = 4'd4; tick("R4");

        // R5 same-bank clash: store dropped, memory unchanged
        idle(); ld_valid = 1; ld_addr = a; ld_idx = 4'd10;
        st_valid = 1; st_phase = 1; st_addr = a2; st_idx = 4'd11; st_way = 2'd0;
        st_data = 64'h5555_5555_5555_5555; st_be = 8'hFF; tick("R5");
        idle(); ld_valid = 1; ld_addr = a2; ld_idx = 4'd12; tick("R5");

        // R6 different banks both proceed
        idle(); ld_valid = 1; ld_addr = a; ld_idx = 4'd13;
        st_valid = 1; st_phase = 1; st_addr = a3; st_idx = 4'd14; st_way = 2'd2;
        st_data = 64'h7777_8888_9999_0000; st_be = 8'hFF; tick("R6");
        idle(); ld_valid = 1; ld_addr = a3; ld_idx = 4'd15; tick("R6");

        // R3 tag check in the load's bank is never rejected
        idle(); ld_valid = 1; ld_addr = a; ld_idx = 4'd0;
        st_valid = 1; st_phase = 0; st_addr = a2; st_idx = 4'd9; tick("R3");

        // R7 two clashes in a row
        idle(); ld_valid = 1; ld_addr = a; ld_idx = 4'd1;
        st_valid = 1; st_phase = 1; st_addr = a2; st_idx = 4'd2; st_be = 8'hFF; tick("R7");
        st_idx = 4'd3; tick("R7");
        idle(); repeat (4) tick("R7");

        // random traffic over a small address pool
        for (int i = 0; i < 4000; i++) begin
            idle();
            ld_valid = ($urandom_range(0, 99) < 60);
            ld_addr  = mk($urandom_range(1, 3), $urandom_range(0, 3), $urandom_range(0, 3));
            ld_idx   = 4'($urandom);
            st_valid = ($urandom_range(0, 99) < 60);
            st_phase = ($urandom_range(0, 99) < 55);
            st_addr  = mk($urandom_range(1, 3), $urandom_range(0, 3), $urandom_range(0, 3));
            st_idx   = 4'($urandom);
            st_way   = 2'($urandom);
            st_data  = {$urandom, $urandom};
            st_be    = ($urandom_range(0, 1) == 1) ? 8'hFF : 8'($urandom);
            if ($urandom_range(0, 99) < 10) begin
                int fw = lookup(mk($urandom_range(1, 3), 0, 0));
                fill_addr  = mk($urandom_range(1, 3), $urandom_range(0, 3), 0);
                fill_way   = 2'($urandom);
                fw = lookup(fill_addr);
                fill_valid = (fw < 0) || (fw == int'(fill_way));
            end
            tick("R2 R3 R5 R6 R7");
        end
        idle(); repeat (4) tick("R2");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule